// File: doc/BRIEF.md
# Fast Ethernet Transmit Encoding Path

This block turns nibble-wide frame data from a MAC into the three-level line signal of a 100 Mb/s twisted-pair transmitter. It runs from a single bit-rate clock. Once in every five cycles it raises a take strobe, and at that edge it samples a 4-bit nibble together with its enable and error qualifiers. The MAC uses the strobe as its nibble clock.

The sampled nibble is mapped to a 5-bit code-group. Control code-groups mark the start and end of a frame and fill the gaps between frames. The code-group is shifted out one bit per clock and XORed with an 11-bit LFSR key stream. The result is NRZI coded and then stepped through the four-phase MLT-3 level cycle. The level is presented as a 2-bit signed code for the analog driver.

Top module: `fetx_tx_path`

## Requirements
- R1: While rst_ni is low, mlt_o is 00 (zero level) and nib_take_o is low. After release, idle symbols are sent until a frame starts.
- R2: At a take edge in the idle state with tx_en_i low, the symbol sent next is IDLE, 11111.
- R3: The first take edge with tx_en_i high sends J (11000) and the next one sends K (10001), in place of those two nibbles. A new frame may start at the take edge right after R.
- R4: At a take edge inside a frame with tx_en_i high and tx_er_i low, the nibble is sent with this mapping: 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R5: In a frame, tx_er_i high with tx_en_i high replaces the data symbol with H (00100). tx_er_i high at the edge where tx_en_i is low does not prevent the end symbols.
- R6: The first take edge inside a frame with tx_en_i low sends T (01101). The next take edge sends R (00111) whatever the inputs are, and IDLE follows after that.
- R7: Every serial bit is XORed with a key bit. The key comes from an 11-bit LFSR (x^11 + x^9 + 1) that advances on every clock: feedback s[10]^s[8] shifts in at bit 0, and the key is s[10]. The LFSR is seeded nonzero and never reaches all zeros.
- R8: nib_take_o is high for one cycle in every five, and the inputs are sampled at that edge. The new symbol is shifted out most significant bit first, one bit per clock.
- R9: The NRZI level toggles on a 1 and holds on a 0. The MLT-3 level steps 0, +1, 0, -1 on each NRZI transition and holds otherwise. The level codes are 00 for zero, 01 for +1 and 11 for -1, and 10 never appears.
- R10: tx_er_i is ignored while no frame is in progress: idle symbols continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 4 | Transmit nibble |
| tx_en_i | input | 1 | Nibble valid / frame in progress |
| tx_er_i | input | 1 | Transmit error request |
| nib_take_o | output | 1 | High in the cycle whose closing edge samples the inputs |
| mlt_o | output | 2 | Signed line level: 00 zero, 01 +1, 11 -1 |

## Verification
The end of a frame and an error request can fall on the same take edge, because the MAC may still hold tx_er_i when it drops tx_en_i. The bench provokes this by sending a frame with an error on one mid-frame nibble. It then keeps tx_er_i high through both end-of-frame edges. The line output is decoded back to bits, descrambled by a receiver-style LFSR that locks on idle, and aligned on J/K. The run passes only if H appears exactly at the error nibble and T, R and idle still follow. A second overlap checks that a frame start lands directly on the edge after R.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] SYM_I = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_H = 5'b00100;

  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  typedef enum logic [1:0] {
    FR_IDLE, FR_KPEND, FR_DATA, FR_RPEND
  } fr_state_e;

  function automatic logic [SYM_W-1:0] enc_nib(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    unique case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fetx_symgen.sv
module fetx_symgen
  import fetx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             idle_o,
  output logic             data_o
);
  fr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    sym_o   = SYM_I;
    unique case (state_q)
      FR_IDLE: begin
        if (tx_en_i) begin
          sym_o   = SYM_J;
          state_d = FR_KPEND;
        end
      end
      FR_KPEND: begin
        sym_o   = SYM_K;
        state_d = FR_DATA;
      end
      FR_DATA: begin
        if (tx_en_i) begin
          sym_o = tx_er_i ? SYM_H : enc_nib(txd_i);
        end else begin
          sym_o   = SYM_T;
          state_d = FR_RPEND;
        end
      end
      default: begin
        sym_o   = SYM_R;
        state_d = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= FR_IDLE;
    else if (take_i) state_q <= state_d;
  end

  assign idle_o = (state_q == FR_IDLE);
  assign data_o = (state_q == FR_DATA);

  // a frame always closes with R one strobe after T
  assert_r_follows_t_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && state_q == FR_RPEND) |=> (state_q == FR_IDLE));
endmodule

// File: rtl/fetx_serializer.sv
module fetx_serializer
  import fetx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] sym_i,
  output logic             take_o,
  output logic             bit_o,
  output logic [SYM_W-1:0] sym_cur_o
);
  localparam int PH_W = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

  logic [PH_W-1:0]  phase_q;
  logic [SYM_W-1:0] sh_q;

  assign take_o = (phase_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      sh_q      <= SYM_I;
      sym_cur_o <= SYM_I;
    end else if (take_o) begin
      phase_q   <= '0;
      sh_q      <= sym_i;
      sym_cur_o <= sym_i;
    end else begin
      phase_q <= phase_q + 1'b1;
      sh_q    <= {sh_q[SYM_W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[SYM_W-1];

  assert_take_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  assert_msb_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (bit_o == $past(sym_i[SYM_W-1])));
endmodule

// File: rtl/fetx_scrambler.sv
module fetx_scrambler #(
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic scr_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic key, fb;

  assign key = lfsr_q[LFSR_W-1];
  assign fb  = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= LFSR_SEED;
      scr_o  <= 1'b0;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      scr_o  <= bit_i ^ key;
    end
  end

  assert_lfsr_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  assert_scr_mix_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (scr_o == ($past(bit_i) ^ $past(lfsr_q[LFSR_W-1]))));
endmodule

// File: rtl/fetx_line.sv
module fetx_line
  import fetx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scr_i,
  output logic [1:0] mlt_o
);
  logic       nrzi_q, nrzi_prev_q;
  logic [1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrzi_q      <= 1'b0;
      nrzi_prev_q <= 1'b0;
      idx_q       <= '0;
    end else begin
      nrzi_q      <= nrzi_q ^ scr_i;
      nrzi_prev_q <= nrzi_q;
      if (nrzi_q != nrzi_prev_q) idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    unique case (idx_q)
      2'd1:    mlt_o = LVL_POS;
      2'd3:    mlt_o = LVL_NEG;
      default: mlt_o = LVL_ZERO;
    endcase
  end

  assert_mlt_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mlt_o != 2'b10);
  assert_mlt_no_jump_pos_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlt_o == LVL_POS) |=> (mlt_o != LVL_NEG));
  assert_mlt_no_jump_neg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlt_o == LVL_NEG) |=> (mlt_o != LVL_POS));
  assert_mlt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scr_i |=> ##1 $stable(mlt_o));
endmodule

// File: rtl/fetx_tx_path.sv
module fetx_tx_path
  import fetx_pkg::*;
#(
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  output logic             nib_take_o,
  output logic [1:0]       mlt_o
);
  logic [SYM_W-1:0] sym_next, sym_cur;
  logic             fr_idle, fr_data;
  logic             ser_bit, scr_bit;

  fetx_symgen u_symgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (nib_take_o),
    .txd_i   (txd_i),
    .tx_en_i (tx_en_i),
    .tx_er_i (tx_er_i),
    .sym_o   (sym_next),
    .idle_o  (fr_idle),
    .data_o  (fr_data)
  );

  fetx_serializer u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sym_i     (sym_next),
    .take_o    (nib_take_o),
    .bit_o     (ser_bit),
    .sym_cur_o (sym_cur)
  );

  fetx_scrambler #(
    .LFSR_W    (LFSR_W),
    .LFSR_TAP  (LFSR_TAP),
    .LFSR_SEED (LFSR_SEED)
  ) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (ser_bit),
    .scr_o  (scr_bit)
  );

  fetx_line u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scr_i  (scr_bit),
    .mlt_o  (mlt_o)
  );

  assert_idle_sym_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_take_o && fr_idle && !tx_en_i) |=> (sym_cur == SYM_I));
  assert_start_j_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_take_o && fr_idle && tx_en_i) |=> (sym_cur == SYM_J));
  assert_err_h_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_take_o && fr_data && tx_en_i && tx_er_i) |=> (sym_cur == SYM_H));
  assert_end_t_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_take_o && fr_data && !tx_en_i) |=> (sym_cur == SYM_T));
  assert_reset_level_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (mlt_o == LVL_ZERO && !nib_take_o));
endmodule

// File: tb/sim_fetx_tx_path.sv
module sim_fetx_tx_path;
  localparam int DB = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] txd = '0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic       nib_take;
  logic [1:0] mlt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fetx_tx_path u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .txd_i      (txd),
    .tx_en_i    (tx_en),
    .tx_er_i    (tx_er),
    .nib_take_o (nib_take),
    .mlt_o      (mlt)
  );

  // ---------------- line monitor / receiver model ----------------
  bit         dbits [DB];
  int         widx = 0;
  int         nraw = 0;
  bit         rec_on = 1'b0;
  logic [10:0] key_sr = '0;
  logic [1:0] prev_lvl = 2'b00;
  logic [1:0] lastnz = 2'b11;
  int         mlt_bad = 0;

  always @(negedge clk) begin
    logic [1:0] lvl;
    logic r, kb;
    if (rst_n) begin
      lvl = mlt;
      if (lvl == 2'b10) mlt_bad++;
      if (lvl != prev_lvl) begin
        if (prev_lvl != 2'b00 && lvl != 2'b00) mlt_bad++;
        if (prev_lvl == 2'b00 && lvl == lastnz) mlt_bad++;
      end
      if (lvl != 2'b00) lastnz = lvl;
      if (rec_on) begin
        r = (lvl != prev_lvl);
        if (nraw < 11) begin
          key_sr = {key_sr[9:0], ~r};  // idle is all ones: key = ~line bit
          nraw++;
        end else begin
          kb = key_sr[10] ^ key_sr[8];
          key_sr = {key_sr[9:0], kb};
          if (widx < DB) dbits[widx] = r ^ kb;
          widx++;
        end
      end
      prev_lvl = lvl;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] get_sym(input int p);
    return {dbits[p], dbits[p+1], dbits[p+2], dbits[p+3], dbits[p+4]};
  endfunction

  function automatic int dec_sym(input logic [4:0] s);
    case (s)
      5'b11110: return 0;  5'b01001: return 1;  5'b10100: return 2;
      5'b10101: return 3;  5'b01010: return 4;  5'b01011: return 5;
      5'b01110: return 6;  5'b01111: return 7;  5'b10010: return 8;
      5'b10011: return 9;  5'b10110: return 10; 5'b10111: return 11;
      5'b11010: return 12; 5'b11011: return 13; 5'b11100: return 14;
      5'b11101: return 15; 5'b00100: return 16;
      default:  return 99;
    endcase
  endfunction

  function automatic int find_jk(input int from);
    for (int p = from; p + 10 <= widx; p++)
      if (get_sym(p) == 5'b11000 && get_sym(p+5) == 5'b10001) return p;
    return -1;
  endfunction

  function automatic int count_zeros(input int from, input int to);
    int z = 0;
    for (int p = from; p < to; p++) if (!dbits[p]) z++;
    return z;
  endfunction

  task automatic drive_nib(input bit en, input logic [3:0] d, input bit er);
    @(negedge clk);
    while (!nib_take) @(negedge clk);
    tx_en = en;
    txd   = d;
    tx_er = er;
  endtask

  int src [64];
  int exp_nib [2][64];
  int exp_cnt [2];

  task automatic send_frame(input int slot, input int n, input int er_at, input bit er_tail);
    exp_cnt[slot] = 0;
    for (int i = 0; i < n; i++) begin
      drive_nib(1'b1, src[i][3:0], (i == er_at));
      if (i >= 2) begin
        exp_nib[slot][exp_cnt[slot]] = (i == er_at) ? 16 : src[i];
        exp_cnt[slot]++;
      end
    end
    drive_nib(1'b0, 4'h0, er_tail);
    drive_nib(1'b0, 4'h0, er_tail);
  endtask

  task automatic settle();
    @(negedge clk);
    tx_er = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic check_frame(input int slot, input int from, input string req,
                             output int j_at, output int after);
    int p, n, bad, first_act, first_exp;
    logic [4:0] s;
    j_at = find_jk(from);
    chk(j_at >= 0, "R3", "J/K start pair found", j_at, from);
    if (j_at < 0) begin
      after = from;
      return;
    end
    p = j_at + 10; n = 0; bad = 0; first_act = 0; first_exp = 0;
    while (n < 64 && p + 5 <= widx) begin
      s = get_sym(p);
      if (s == 5'b01101) break;
      if (n < exp_cnt[slot] && dec_sym(s) != exp_nib[slot][n]) begin
        if (bad == 0) begin
          first_act = dec_sym(s);
          first_exp = exp_nib[slot][n];
        end
        bad++;
      end
      n++;
      p += 5;
    end
    chk(n == exp_cnt[slot], req, "symbol count before T", n, exp_cnt[slot]);
    chk(bad == 0, req, "first mismatching nibble", first_act, first_exp);
    chk(get_sym(p) == 5'b01101 && get_sym(p+5) == 5'b00111, "R6",
        "T R end pair", int'({get_sym(p), get_sym(p+5)}), int'({5'b01101, 5'b00111}));
    after = p + 10;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    int gap;
    repeat (3) @(negedge clk);
    chk(mlt == 2'b00, "R1", "mlt_o in reset", mlt, 0);
    chk(nib_take == 1'b0, "R1", "nib_take_o in reset", nib_take, 0);
    rst_n = 1'b1;
    @(negedge clk);
    while (!nib_take) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!nib_take);
    chk(gap == 5, "R8", "take strobe period", gap, 5);
  endtask

  task automatic t_idle();
    int m;
    repeat (20) @(negedge clk);
    rec_on = 1'b1;
    repeat (150) @(negedge clk);
    m = widx;
    chk(widx > 100 && count_zeros(0, m) == 0, "R7",
        "descrambled idle zeros (LFSR key prediction)", count_zeros(0, m), 0);
    chk(count_zeros(0, m) == 0, "R2", "idle stream zeros", count_zeros(0, m), 0);
    tx_er = 1'b1;
    repeat (120) @(negedge clk);
    tx_er = 1'b0;
    chk(count_zeros(m, widx) == 0, "R10", "zeros with tx_er high in idle",
        count_zeros(m, widx), 0);
  endtask

  task automatic t_full();
    int mark, j, after;
    for (int i = 0; i < 15; i++) src[i] = 5;
    src[15] = 13;
    for (int i = 0; i < 16; i++) src[16+i] = i;
    mark = widx;
    send_frame(0, 32, -1, 1'b0);
    settle();
    check_frame(0, mark, "R4", j, after);
    chk(count_zeros(mark, j) == 0, "R2", "idle before frame", count_zeros(mark, j), 0);
    chk(widx - after > 40 && count_zeros(after, widx) == 0, "R6",
        "idle after R", count_zeros(after, widx), 0);
  endtask

  task automatic t_err_at_end();
    int mark, j, after;
    for (int i = 0; i < 12; i++) src[i] = (i * 7 + 3) % 16;
    mark = widx;
    send_frame(0, 12, 6, 1'b1);  // tx_er also held while tx_en drops
    settle();
    check_frame(0, mark, "R5", j, after);
    chk(count_zeros(after, widx) == 0, "R5", "idle after errored frame",
        count_zeros(after, widx), 0);
  endtask

  task automatic t_short();
    int mark, j, after;
    src[0] = 5;
    mark = widx;
    send_frame(0, 1, -1, 1'b0);
    settle();
    check_frame(0, mark, "R3", j, after);
  endtask

  task automatic t_back_to_back();
    int mark, j0, a0, j1, a1;
    for (int i = 0; i < 8; i++) src[i] = 15 - i;
    mark = widx;
    send_frame(0, 8, -1, 1'b0);
    for (int i = 0; i < 8; i++) src[i] = (i + 9) % 16;
    send_frame(1, 8, -1, 1'b0);
    settle();
    check_frame(0, mark, "R4", j0, a0);
    check_frame(1, a0, "R4", j1, a1);
    chk(j1 == a0, "R3", "J directly after R", j1, a0);
  endtask

  task automatic t_line();
    chk(mlt_bad == 0, "R9", "MLT-3 order/code violations", mlt_bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_full();
    t_err_at_end();
    t_short();
    t_back_to_back();
    t_line();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule